// File: doc/BRIEF.md
# Flash command sequence decoder

This block sits on the write side of a byte-wide flash memory port. It watches each byte write (a strobe with a 19-bit address and a data byte) and recognises the multi-write unlock sequences that move the memory between its operating modes. These modes are normal read, sector load with writes enabled, and product identification. The block also recognises the longer sequence that arms the lockout of one of the two boot blocks.

A completed program-enable sequence puts the block in sector-load mode and emits a one-cycle pulse that opens the sector load. While that mode is active, writes belong to the sector buffer and are not decoded. The block returns to read mode when the external programming logic signals that the program cycle has ended, so every program operation needs a fresh unlock.

A completed lockout sequence emits a one-cycle set request for the chosen block and sets a sticky lock flag. In identification mode the read port returns the manufacturer and device codes and the lock status of each boot block. A write that no sequence accepts produces a pulse that can start the external write timer.

Top module: `flash_cmd_decoder`

## Requirements
- R1: After reset `mode` is 0 (read), all pulse outputs and `id_hit` are low, and both boot blocks report unlocked.
- R2: Writes of AA to 5555, then 55 to 2AAA, then A0 to 5555 set `mode` to 1 (sector load). `load_open` is high for exactly the one cycle after the third write.
- R3: Sequence steps compare only address bits 14:0. Address bits 18:15 have no effect on them.
- R4: In mode 1, writes are not decoded and do not raise `stray_wr`. `prog_done` returns `mode` to 0 on the next cycle, and `prog_done` has no effect in other modes.
- R5: The prefix AA@5555, 55@2AAA followed by 90@5555 sets `mode` to 2 (identification). The same prefix followed by F0@5555 sets `mode` to 0.
- R6: In mode 2, a read at address 0 returns 1F and a read at address 1 returns C4, each with `id_hit` high. Other addresses apart from the two status addresses give `id_hit` low and `id_data` 00. Outside mode 2, `id_hit` is always low.
- R7: In mode 2, a read at 00002 reports the lower boot block and a read at 7FFF2 reports the upper boot block. The value is FE when the block is unlocked and FF when it is locked. All 19 address bits are compared.
- R8: The six writes AA@5555, 55@2AAA, 80@5555, AA@5555, 55@2AAA, 40@5555 must be followed by a seventh write. That write is 00 to 00000 to lock the lower block (`lock_set_lo` pulses for one cycle) or FF to 7FFFF to lock the upper block (`lock_set_hi` pulses for one cycle). For the seventh write all 19 address bits are compared. Any other seventh write locks nothing.
- R9: A lock, once set, stays set through mode changes and further sequences until reset.
- R10: A write that is not the expected next step aborts the sequence, and that same write is then tried as the first step (AA@5555) of a new sequence.
- R11: In modes 0 and 2, `stray_wr` pulses for one cycle after any write that neither advances nor restarts a sequence and completes no command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_valid | input | 1 | A byte write is present this cycle |
| wr_addr | input | 19 | Write address |
| wr_data | input | 8 | Write data |
| prog_done | input | 1 | The external program cycle has finished |
| rd_addr | input | 19 | Read address for identification readback |
| mode | output | 2 | 0 read, 1 sector load, 2 identification |
| load_open | output | 1 | One-cycle pulse that opens a sector load |
| lock_set_lo | output | 1 | One-cycle request to lock the lower boot block |
| lock_set_hi | output | 1 | One-cycle request to lock the upper boot block |
| stray_wr | output | 1 | One-cycle pulse for a write that no sequence accepts |
| id_hit | output | 1 | Read address is an identification or status location |
| id_data | output | 8 | Identification or status byte |

## Verification
A wrong sequence state is hidden until the step that completes a command. It shows one cycle after that write, as a missing or extra `load_open` or lock pulse, a wrong `mode`, or a `stray_wr` pulse where a step should have been accepted. A lock flag that is set or cleared wrongly is visible only through the status reads in identification mode, and the bench reads it there straight after each lock sequence and again after mode changes and reset. The third write of the shared prefix is swept over all 256 data values. Every identification address neighbourhood is swept at both ends of the address space.

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder #(
  parameter int ADDR_W = 19,
  parameter int DATA_W = 8,
  parameter int CMD_AW = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              prog_done,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [1:0]        mode,
  output logic              load_open,
  output logic              lock_set_lo,
  output logic              lock_set_hi,
  output logic              stray_wr,
  output logic              id_hit,
  output logic [DATA_W-1:0] id_data
);

  localparam logic [1:0] M_READ  = 2'd0;
  localparam logic [1:0] M_LOAD  = 2'd1;
  localparam logic [1:0] M_IDENT = 2'd2;

  localparam logic [CMD_AW-1:0] KEY_A = CMD_AW'(15'h5555);
  localparam logic [CMD_AW-1:0] KEY_B = CMD_AW'(15'h2AAA);
  localparam logic [ADDR_W-1:0] TOP_ADDR = {ADDR_W{1'b1}};
  localparam logic [ADDR_W-1:0] STAT_LO  = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] STAT_HI  = TOP_ADDR - ADDR_W'(13);

  localparam logic [DATA_W-1:0] D_AA  = DATA_W'(8'hAA);
  localparam logic [DATA_W-1:0] D_55  = DATA_W'(8'h55);
  localparam logic [DATA_W-1:0] D_PRG = DATA_W'(8'hA0);
  localparam logic [DATA_W-1:0] D_IDN = DATA_W'(8'h90);
  localparam logic [DATA_W-1:0] D_EXT = DATA_W'(8'hF0);
  localparam logic [DATA_W-1:0] D_ARM = DATA_W'(8'h80);
  localparam logic [DATA_W-1:0] D_BLK = DATA_W'(8'h40);
  localparam logic [DATA_W-1:0] D_LO  = DATA_W'(8'h00);
  localparam logic [DATA_W-1:0] D_HI  = DATA_W'(8'hFF);
  localparam logic [DATA_W-1:0] C_MFR = DATA_W'(8'h1F);
  localparam logic [DATA_W-1:0] C_DEV = DATA_W'(8'hC4);
  localparam logic [DATA_W-1:0] C_FREE = DATA_W'(8'hFE);
  localparam logic [DATA_W-1:0] C_LOCK = DATA_W'(8'hFF);

  typedef enum logic [2:0] {
    S_IDLE, S_P1, S_P2, S_A3, S_A4, S_A5, S_A6
  } step_t;

  step_t       st, st_nx;
  logic [1:0]  mode_nx;
  logic        lock_lo, lock_hi;
  logic        matched, go_load, go_lo, go_hi;

  wire          decode = wr_valid && (mode != M_LOAD);
  wire          at_a   = (wr_addr[CMD_AW-1:0] == KEY_A);
  wire          at_b   = (wr_addr[CMD_AW-1:0] == KEY_B);
  wire          first  = at_a && (wr_data == D_AA);
  wire          second = at_b && (wr_data == D_55);

  always_comb begin
    st_nx   = st;
    mode_nx = mode;
    matched = 1'b0;
    go_load = 1'b0;
    go_lo   = 1'b0;
    go_hi   = 1'b0;
    if (mode == M_LOAD) begin
      st_nx = S_IDLE;
      if (prog_done) mode_nx = M_READ;
    end else if (decode) begin
      unique case (st)
        S_P1: if (second) begin matched = 1'b1; st_nx = S_P2; end
        S_P2: if (at_a) begin
          if (wr_data == D_PRG) begin
            matched = 1'b1; st_nx = S_IDLE; mode_nx = M_LOAD; go_load = 1'b1;
          end else if (wr_data == D_IDN) begin
            matched = 1'b1; st_nx = S_IDLE; mode_nx = M_IDENT;
          end else if (wr_data == D_EXT) begin
            matched = 1'b1; st_nx = S_IDLE; mode_nx = M_READ;
          end else if (wr_data == D_ARM) begin
            matched = 1'b1; st_nx = S_A3;
          end
        end
        S_A3: if (first) begin matched = 1'b1; st_nx = S_A4; end
        S_A4: if (second) begin matched = 1'b1; st_nx = S_A5; end
        S_A5: if (at_a && wr_data == D_BLK) begin matched = 1'b1; st_nx = S_A6; end
        S_A6: begin
          if (wr_addr == '0 && wr_data == D_LO) begin
            matched = 1'b1; st_nx = S_IDLE; go_lo = 1'b1;
          end else if (wr_addr == TOP_ADDR && wr_data == D_HI) begin
            matched = 1'b1; st_nx = S_IDLE; go_hi = 1'b1;
          end
        end
        default: ;
      endcase
      if (!matched) st_nx = first ? S_P1 : S_IDLE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st          <= S_IDLE;
      mode        <= M_READ;
      load_open   <= 1'b0;
      lock_set_lo <= 1'b0;
      lock_set_hi <= 1'b0;
      stray_wr    <= 1'b0;
      lock_lo     <= 1'b0;
      lock_hi     <= 1'b0;
    end else begin
      st          <= st_nx;
      mode        <= mode_nx;
      load_open   <= go_load;
      lock_set_lo <= go_lo;
      lock_set_hi <= go_hi;
      stray_wr    <= decode && !matched && !first;
      if (go_lo) lock_lo <= 1'b1;
      if (go_hi) lock_hi <= 1'b1;
    end
  end

  assign id_hit = (mode == M_IDENT) &&
                  (rd_addr == '0 || rd_addr == ADDR_W'(1) ||
                   rd_addr == STAT_LO || rd_addr == STAT_HI);

  always_comb begin
    id_data = '0;
    if (id_hit) begin
      if (rd_addr == '0)           id_data = C_MFR;
      else if (rd_addr == STAT_LO) id_data = lock_lo ? C_LOCK : C_FREE;
      else if (rd_addr == STAT_HI) id_data = lock_hi ? C_LOCK : C_FREE;
      else                         id_data = C_DEV;
    end
  end

  p_mode_legal_r1: assert property (@(posedge clk) disable iff (!rst_n)
    mode != 2'd3);
  p_load_mode_r2: assert property (@(posedge clk) disable iff (!rst_n)
    load_open |-> mode == M_LOAD);
  p_load_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
    load_open |=> !load_open);
  p_load_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == M_LOAD && !prog_done) |=> mode == M_LOAD);
  p_load_exit_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == M_LOAD && prog_done) |=> mode == M_READ);
  p_id_mode_r6: assert property (@(posedge clk) disable iff (!rst_n)
    id_hit |-> mode == M_IDENT);
  p_pulse_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({load_open, lock_set_lo, lock_set_hi, stray_wr}));
  p_lock_req_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_set_lo |-> lock_lo) and (lock_set_hi |-> lock_hi));
  p_lock_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_lo |=> lock_lo) and (lock_hi |=> lock_hi));
  p_no_stray_load_r11: assert property (@(posedge clk) disable iff (!rst_n)
    mode == M_LOAD |=> !stray_wr);

endmodule

// File: tb/sim_flash_cmd_decoder.sv
`timescale 1ns/1ps
module sim_flash_cmd_decoder;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_valid = 1'b0;
  logic [18:0] wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic        prog_done = 1'b0;
  logic [18:0] rd_addr = '0;
  logic [1:0]  mode;
  logic        load_open, lock_set_lo, lock_set_hi, stray_wr, id_hit;
  logic [7:0]  id_data;
  int nchk = 0;
  int nerr = 0;
  int cyc = 0;

  flash_cmd_decoder u0 (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_addr(wr_addr),
    .wr_data(wr_data), .prog_done(prog_done), .rd_addr(rd_addr),
    .mode(mode), .load_open(load_open), .lock_set_lo(lock_set_lo),
    .lock_set_hi(lock_set_hi), .stray_wr(stray_wr), .id_hit(id_hit),
    .id_data(id_data));

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [18:0] a, input logic [7:0] d);
    @(negedge clk); wr_valid = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_valid = 1'b0;
  endtask

  task automatic pdone();
    @(negedge clk); prog_done = 1'b1;
    @(negedge clk); prog_done = 1'b0;
  endtask

  task automatic rd(input logic [18:0] a);
    rd_addr = a; #0.5;
  endtask

  task automatic prefix();
    wr(19'h05555, 8'hAA); wr(19'h02AAA, 8'h55);
  endtask

  task automatic enter_id();
    prefix(); wr(19'h05555, 8'h90);
  endtask

  task automatic exit_id();
    prefix(); wr(19'h05555, 8'hF0);
  endtask

  task automatic arm();
    prefix(); wr(19'h05555, 8'h80);
    prefix(); wr(19'h05555, 8'h40);
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
  endtask

  initial begin
    @(negedge clk); @(negedge clk); rst_n = 1'b1;
    chk("R1 mode after reset", mode, 0);
    chk("R1 pulses after reset", {load_open, lock_set_lo, lock_set_hi, stray_wr}, 0);
    rd(19'h0); chk("R1 id_hit after reset", id_hit, 0);

    for (int d = 0; d < 256; d++) begin
      logic [1:0] em;
      logic es;
      prefix(); wr(19'h05555, 8'(d));
      em = (d == 8'hA0) ? 2'd1 : (d == 8'h90) ? 2'd2 : 2'd0;
      es = !(d == 8'hA0 || d == 8'h90 || d == 8'hF0 || d == 8'h80 || d == 8'hAA);
      chk("R2/R5 mode after third write", mode, em);
      chk("R2 load_open after third write", load_open, (d == 8'hA0));
      chk("R11 stray after third write", stray_wr, es);
      if (d == 8'hA0) begin
        @(negedge clk); chk("R2 load_open single cycle", load_open, 0);
        pdone(); chk("R4 prog_done returns to read", mode, 0);
      end else if (d == 8'h90) begin
        exit_id(); chk("R5 exit to read", mode, 0);
      end else if (d == 8'h80 || d == 8'hAA) begin
        wr(19'h0, 8'h00); chk("R10 abort write is stray", stray_wr, 1);
      end
    end

    for (int h = 0; h < 16; h++) begin
      logic [18:0] hb;
      hb = {4'(h), 15'h0};
      wr(hb | 19'h05555, 8'hAA); wr(hb | 19'h02AAA, 8'h55); wr(hb | 19'h05555, 8'hA0);
      chk("R3 upper address bits ignored", mode, 1);
      pdone();
    end

    prefix(); wr(19'h05555, 8'hA0);
    enter_id();
    chk("R4 load mode ignores commands", mode, 1);
    chk("R4 no stray in load mode", stray_wr, 0);
    pdone(); chk("R4 back to read", mode, 0);
    wr(19'h05555, 8'hA0);
    chk("R4 program needs new unlock", mode, 0);
    chk("R11 bare A0 is stray", stray_wr, 1);
    pdone(); chk("R4 prog_done ignored in read", mode, 0);

    enter_id(); chk("R5 enter ident", mode, 2);
    for (int a = 0; a < 16; a++) begin
      rd(19'(a));
      chk("R6/R7 id_hit low range", id_hit, (a < 3));
      chk("R6/R7 id_data low range", id_data,
          (a == 0) ? 8'h1F : (a == 1) ? 8'hC4 : (a == 2) ? 8'hFE : 8'h00);
    end
    for (int a = 0; a < 16; a++) begin
      rd(19'h7FFF0 + 19'(a));
      chk("R7 id_hit high range", id_hit, (a == 2));
      chk("R7 id_data high range", id_data, (a == 2) ? 8'hFE : 8'h00);
    end
    rd(19'h40002); chk("R7 full address compared", id_hit, 0);

    arm(); wr(19'h0, 8'h00);
    chk("R8 lock_set_lo pulse", lock_set_lo, 1);
    chk("R8 no lock_set_hi", lock_set_hi, 0);
    @(negedge clk); chk("R8 lock_set_lo single cycle", lock_set_lo, 0);
    rd(19'h00002); chk("R7 lower locked", id_data, 8'hFF);
    rd(19'h7FFF2); chk("R7 upper still free", id_data, 8'hFE);

    arm(); wr(19'h00001, 8'h00);
    chk("R8 wrong block address locks nothing", {lock_set_lo, lock_set_hi}, 0);
    chk("R11 wrong seventh write is stray", stray_wr, 1);
    arm(); wr(19'h07FFF, 8'hFF);
    chk("R8 upper address needs all bits", lock_set_hi, 0);
    rd(19'h7FFF2); chk("R8 upper not locked by partial address", id_data, 8'hFE);
    arm(); wr(19'h7FFFF, 8'hFF);
    chk("R8 lock_set_hi pulse", lock_set_hi, 1);
    rd(19'h7FFF2); chk("R7 upper locked", id_data, 8'hFF);
    chk("R8 mode unchanged by lock", mode, 2);

    exit_id(); rd(19'h00002); chk("R6 no id_hit in read mode", id_hit, 0);
    prefix(); wr(19'h05555, 8'hA0); pdone();
    enter_id();
    rd(19'h00002); chk("R9 lower lock sticky", id_data, 8'hFF);
    rd(19'h7FFF2); chk("R9 upper lock sticky", id_data, 8'hFF);

    do_reset();
    chk("R1 mode after second reset", mode, 0);
    enter_id();
    rd(19'h00002); chk("R1 lower unlocked after reset", id_data, 8'hFE);
    rd(19'h7FFF2); chk("R1 upper unlocked after reset", id_data, 8'hFE);
    exit_id();

    wr(19'h05555, 8'hAA); wr(19'h05555, 8'hAA);
    chk("R10 repeated AA restarts, no stray", stray_wr, 0);
    wr(19'h02AAA, 8'h55); wr(19'h05555, 8'hA0);
    chk("R10 restart completes program enable", mode, 1);
    pdone();
    wr(19'h05555, 8'hAA); wr(19'h00000, 8'h00);
    chk("R10 abort is stray", stray_wr, 1);
    wr(19'h02AAA, 8'h55); chk("R11 orphan second step is stray", stray_wr, 1);
    wr(19'h05555, 8'hA0); chk("R10 aborted sequence does not enable", mode, 0);

    $display("CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end

  initial begin
    wait (cyc > 150000);
    nchk++; nerr++;
    $display("FAIL watchdog actual=%0d expected=<150000", cyc);
    $display("CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end
endmodule